// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial datapath of an SPI master. Software-side logic writes 32-bit words into an internal transmit queue. While `run` is high the engine takes one word at a time, drives the requested number of bits (4 to 32) on `mosi` most significant bit first, and captures the same number of bits from `miso` (or from its own transmit stream in loopback). Each captured word is pushed into an internal receive queue, which the host drains with a read strobe.

The serial clock comes from the core clock through a half-period divider. Its resting level and the edge on which input is sampled are both configurable. Six sticky error flags record misuse of either queue and disturbances of the serial clock during a word. A flag stays set until it is written with 1 through `err_clr`.

Top module: `spi_shift_engine`

## Requirements
- R1: `cfg_bits_m1` holds the word length minus one, giving N = `cfg_bits_m1`+1 bits per word and 2N serial clock edges per word. Values below 3 are treated as 3, so a word is never shorter than 4 bits.
- R2: Transmission is left-justified and MSB first. Bits 31 down to 32-N of the queued word appear on `mosi` in that order, and bits below 32-N are never sent.
- R3: Received words are right-justified. The first bit received lands in bit N-1, the last in bit 0, and bits 31:N read 0.
- R4: With `cfg_input_first`=1, input is sampled on every leading (away-from-idle) edge, the first bit is on `mosi` before the first edge, and later bits change on trailing edges. With `cfg_input_first`=0, `mosi` changes on leading edges after the first, and input is sampled on trailing edges.
- R5: Between words `sclk` rests at `cfg_clk_idle_high`. Each half period of `sclk` lasts `cfg_half_div` core cycles, and a value of 0 is treated as 1.
- R6: With `cfg_loopback`=1 the received bits are the transmitted bits and `miso` is ignored.
- R7: `status` bit 3 = receive queue full, bit 2 = transmit queue full, bit 1 = receive queue not empty, bit 0 = transmit queue not empty.
- R8: `err_flags` bit 5 is set by a write while the transmit queue is full (the word is dropped). Bit 4 is set by a read while the receive queue is empty.
- R9: `err_flags` bit 3 is set when `run` is high, the engine is idle and the transmit queue is empty. Bit 2 is set when a finished word finds the receive queue full, and that word is dropped while older contents are kept.
- R10: `err_flags` bit 1 is set when `cfg_half_div` differs from the value latched at word start while a word shifts. Bit 0 is set when `run` falls during a word: the word is abandoned, nothing is queued, and `sclk` returns to idle.
- R11: Every flag stays set until a 1 is written to its position in `err_clr`. A 1 in another position leaves it set, and a new event in the same cycle as its clear keeps it set.
- R12: After the synchronous reset all flags are 0, `status` is 0, and `sclk` and `mosi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables word transfers |
| cfg_bits_m1 | input | 5 | Word length minus one |
| cfg_input_first | input | 1 | 1: sample on leading edge |
| cfg_loopback | input | 1 | Receive from own transmit stream |
| cfg_clk_idle_high | input | 1 | Resting level of sclk |
| cfg_half_div | input | 8 | Core cycles per sclk half period |
| out_wr | input | 1 | Write strobe into transmit queue |
| out_wdata | input | 32 | Word to transmit |
| in_rd | input | 1 | Read strobe from receive queue |
| in_rdata | output | 32 | Received word, valid the cycle after in_rd |
| err_clr | input | 6 | Write-1-to-clear of error flags |
| err_flags | output | 6 | Sticky error flags |
| status | output | 4 | Queue full / not-empty status |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest situation to reach from the ports is the receive queue overflowing. It needs more completed words than the queue holds while nothing is read, and the transmit queue is only as deep as the receive queue. The bench fills the transmit queue, runs until it drains, and then tops it up with one more word so that this word arrives to find the receive queue full. A second hard case is a disturbance in the middle of a word. The bench starts a long, slow word and then changes the divider and drops `run` partway through it. For the edge-phase checks, a slave model in the bench shifts its own pattern on the opposite edge.

// File: rtl/sse_pkg.sv
`timescale 1ns/1ps
package sse_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SHIFT} eng_state_t;
  localparam int ERR_W       = 6;
  localparam int ERR_OUT_OVR = 5;
  localparam int ERR_IN_UDR  = 4;
  localparam int ERR_OUT_UDR = 3;
  localparam int ERR_IN_OVR  = 2;
  localparam int ERR_CLK_OVR = 1;
  localparam int ERR_CLK_UDR = 0;
endpackage

// File: rtl/sse_fifo.sv
`timescale 1ns/1ps
module sse_fifo #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_wr, do_rd;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;

  // storage and read port kept free of reset for RAM inference
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
      else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sse_edge_timer.sv
`timescale 1ns/1ps
module sse_edge_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] half,
  output logic          tick
);
  logic [DW-1:0] cnt, lim;

  assign lim  = (half == '0) ? {{(DW-1){1'b0}}, 1'b1} : half;
  assign tick = en && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sse_shifter.sv
`timescale 1ns/1ps
module sse_shifter
  import sse_pkg::*;
#(
  parameter int DW   = 32,
  parameter int DIVW = 8,
  localparam int LW  = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [LW-1:0]   cfg_bits_m1,
  input  logic            cfg_input_first,
  input  logic            cfg_loopback,
  input  logic            cfg_idle_high,
  input  logic [DIVW-1:0] cfg_half_div,
  input  logic            tx_empty,
  output logic            tx_pop,
  input  logic [DW-1:0]   tx_data,
  output logic            rx_push,
  output logic [DW-1:0]   rx_data,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic            busy,
  output logic            ev_out_udr,
  output logic            ev_clk_ovr,
  output logic            ev_clk_udr
);
  localparam logic [LW-1:0] MIN_BM1 = LW'(3);

  eng_state_t      state;
  logic [DW-1:0]   sr, rx, rx_next;
  logic [LW:0]     edge_q, last_edge;
  logic [LW-1:0]   bm1_q, bm1_eff;
  logic            if_q, lb_q, sclk_q;
  logic [DIVW-1:0] div_q;
  logic            tick, leading, sample_now, launch_now, rx_bit, word_end, abort;

  sse_edge_timer #(.DW(DIVW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (state == ST_SHIFT && run),
    .half (div_q),
    .tick (tick)
  );

  assign bm1_eff    = (cfg_bits_m1 < MIN_BM1) ? MIN_BM1 : cfg_bits_m1;
  assign last_edge  = {bm1_q, 1'b1};
  assign leading    = ~edge_q[0];
  assign sample_now = tick && (if_q ? leading : !leading);
  assign launch_now = tick && (if_q ? (!leading && edge_q != last_edge)
                                    : (leading && edge_q != '0));
  assign rx_bit     = lb_q ? sr[DW-1] : miso;
  assign rx_next    = sample_now ? {rx[DW-2:0], rx_bit} : rx;
  assign word_end   = (state == ST_SHIFT) && tick && (edge_q == last_edge);
  assign abort      = (state != ST_IDLE) && !run;

  assign tx_pop     = (state == ST_IDLE) && run && !tx_empty;
  assign rx_push    = word_end && run;
  assign rx_data    = rx_next;
  assign ev_out_udr = (state == ST_IDLE) && run && tx_empty;
  assign ev_clk_udr = abort;
  assign ev_clk_ovr = (state == ST_SHIFT) && run && (cfg_half_div != div_q);

  assign sclk = sclk_q;
  assign mosi = sr[DW-1];
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sr     <= '0;
      rx     <= '0;
      edge_q <= '0;
      bm1_q  <= '0;
      if_q   <= 1'b0;
      lb_q   <= 1'b0;
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (abort) begin
      state  <= ST_IDLE;
      sclk_q <= cfg_idle_high;
    end else begin
      case (state)
        ST_IDLE: begin
          sclk_q <= cfg_idle_high;
          if (tx_pop) begin
            state <= ST_FETCH;
            bm1_q <= bm1_eff;
            if_q  <= cfg_input_first;
            lb_q  <= cfg_loopback;
            div_q <= cfg_half_div;
          end
        end
        ST_FETCH: begin
          sr     <= tx_data;
          rx     <= '0;
          edge_q <= '0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            rx     <= rx_next;
            if (launch_now) sr <= sr << 1;
            if (edge_q == last_edge) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
  import sse_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 8,
  parameter int FIFO_AW = 3,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [LEN_W-1:0]  cfg_bits_m1,
  input  logic              cfg_input_first,
  input  logic              cfg_loopback,
  input  logic              cfg_clk_idle_high,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic              out_wr,
  input  logic [DATA_W-1:0] out_wdata,
  input  logic              in_rd,
  output logic [DATA_W-1:0] in_rdata,
  input  logic [ERR_W-1:0]  err_clr,
  output logic [ERR_W-1:0]  err_flags,
  output logic [3:0]        status,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic              out_full, out_empty, in_full, in_empty;
  logic              tx_pop, rx_push, eng_busy;
  logic [DATA_W-1:0] tx_data, rx_data;
  logic              ev_out_udr, ev_clk_ovr, ev_clk_udr;
  logic [ERR_W-1:0]  err_set, err_q;

  sse_fifo #(.W(DATA_W), .AW(FIFO_AW)) u_txq (
    .clk(clk), .rst(rst), .wr(out_wr), .wdata(out_wdata),
    .rd(tx_pop), .rdata(tx_data), .full(out_full), .empty(out_empty)
  );

  sse_fifo #(.W(DATA_W), .AW(FIFO_AW)) u_rxq (
    .clk(clk), .rst(rst), .wr(rx_push), .wdata(rx_data),
    .rd(in_rd), .rdata(in_rdata), .full(in_full), .empty(in_empty)
  );

  sse_shifter #(.DW(DATA_W), .DIVW(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .run(run),
    .cfg_bits_m1(cfg_bits_m1), .cfg_input_first(cfg_input_first),
    .cfg_loopback(cfg_loopback), .cfg_idle_high(cfg_clk_idle_high),
    .cfg_half_div(cfg_half_div),
    .tx_empty(out_empty), .tx_pop(tx_pop), .tx_data(tx_data),
    .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .busy(eng_busy),
    .ev_out_udr(ev_out_udr), .ev_clk_ovr(ev_clk_ovr), .ev_clk_udr(ev_clk_udr)
  );

  always_comb begin
    err_set              = '0;
    err_set[ERR_OUT_OVR] = out_wr && out_full;
    err_set[ERR_IN_UDR]  = in_rd && in_empty;
    err_set[ERR_OUT_UDR] = ev_out_udr;
    err_set[ERR_IN_OVR]  = rx_push && in_full;
    err_set[ERR_CLK_OVR] = ev_clk_ovr;
    err_set[ERR_CLK_UDR] = ev_clk_udr;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (err_q & ~err_clr) | err_set;
  end

  assign err_flags = err_q;
  assign status    = {in_full, out_full, !in_empty, !out_empty};
endmodule

// File: rtl/sse_checker.sv
`timescale 1ns/1ps
module sse_checker (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic       out_wr,
  input logic       in_rd,
  input logic [5:0] err_clr,
  input logic [5:0] err_flags,
  input logic [3:0] status,
  input logic       sclk,
  input logic       cfg_clk_idle_high,
  input logic       busy
);
  a_r8_out_overrun: assert property (@(posedge clk) disable iff (rst)
    (out_wr && status[2]) |=> err_flags[5]);

  a_r8_in_underrun: assert property (@(posedge clk) disable iff (rst)
    (in_rd && !status[1]) |=> err_flags[4]);

  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    (busy && !run) |=> (!busy && err_flags[0]));

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(err_flags) & ~$past(err_clr)) & ~err_flags) == 6'b0));

  a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(rst)) |-> (sclk == $past(cfg_clk_idle_high)));

  a_r7_full_not_empty: assert property (@(posedge clk) disable iff (rst)
    status[3] |-> status[1]);
endmodule

bind spi_shift_engine sse_checker u_chk (
  .clk(clk), .rst(rst), .run(run), .out_wr(out_wr), .in_rd(in_rd),
  .err_clr(err_clr), .err_flags(err_flags), .status(status), .sclk(sclk),
  .cfg_clk_idle_high(cfg_clk_idle_high), .busy(eng_busy)
);

// File: tb/tb_spi_shift_engine.sv
`timescale 1ns/1ps
module tb_spi_shift_engine;
  logic        clk = 1'b0;
  logic        rst, run, cfg_input_first, cfg_loopback, cfg_clk_idle_high;
  logic [4:0]  cfg_bits_m1;
  logic [7:0]  cfg_half_div;
  logic        out_wr, in_rd;
  logic [31:0] out_wdata, in_rdata;
  logic [5:0]  err_clr, err_flags;
  logic [3:0]  status;
  logic        sclk, mosi, miso;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  spi_shift_engine dut (
    .clk(clk), .rst(rst), .run(run), .cfg_bits_m1(cfg_bits_m1),
    .cfg_input_first(cfg_input_first), .cfg_loopback(cfg_loopback),
    .cfg_clk_idle_high(cfg_clk_idle_high), .cfg_half_div(cfg_half_div),
    .out_wr(out_wr), .out_wdata(out_wdata), .in_rd(in_rd), .in_rdata(in_rdata),
    .err_clr(err_clr), .err_flags(err_flags), .status(status),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // slave model: shifts its pattern on launch edges, records mosi on sample edges
  logic        mon_en = 1'b0;
  logic        b_if = 1'b0, b_idle = 1'b0;
  logic [31:0] mon = '0, sd = '0;
  int          eidx = 0;
  time         t_e0 = 0, t_e1 = 0;
  assign miso = sd[31];

  always @(sclk) begin
    if (mon_en) begin
      if (eidx == 0) t_e0 = $time;
      if (eidx == 1) t_e1 = $time;
      if (b_if) begin
        if (sclk != b_idle) mon = {mon[30:0], mosi};
        else                sd  = sd << 1;
      end else begin
        if (sclk != b_idle) begin
          if (eidx != 0) sd = sd << 1;
        end else mon = {mon[30:0], mosi};
      end
      eidx++;
    end
  end

  // bm1, input_first, loopback, idle_high, half_div, tx word, slave pattern
  localparam int NV = 7;
  localparam logic [79:0] VEC [NV] = '{
    {5'd7,  1'b1, 1'b0, 1'b0, 8'd1, 32'hA5123456, 32'h3C000000},
    {5'd15, 1'b0, 1'b0, 1'b0, 8'd2, 32'h1234ABCD, 32'hC3A50F0F},
    {5'd31, 1'b1, 1'b0, 1'b1, 8'd3, 32'hDEADBEEF, 32'h0F1E2D3C},
    {5'd3,  1'b0, 1'b0, 1'b1, 8'd1, 32'h90000000, 32'h60000000},
    {5'd11, 1'b1, 1'b1, 1'b0, 8'd2, 32'hABC00000, 32'hFFFFFFFF},
    {5'd23, 1'b0, 1'b1, 1'b1, 8'd4, 32'h5A3C9611, 32'h00000000},
    {5'd1,  1'b1, 1'b0, 1'b0, 8'd0, 32'hC0000000, 32'hA0000000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; run = 1'b0; out_wr = 1'b0; in_rd = 1'b0; err_clr = '0;
    cyc(2);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic push_word(input logic [31:0] w);
    out_wr = 1'b1; out_wdata = w;
    cyc(1);
    out_wr = 1'b0;
  endtask

  task automatic clear_all();
    err_clr = 6'h3F;
    cyc(1);
    err_clr = '0;
  endtask

  task automatic wait_bit(input int idx, input logic val, input bit on_err);
    for (int k = 0; k < 5000; k++) begin
      if ((on_err ? err_flags[idx] : status[idx]) === val) break;
      cyc(1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cfg_bits_m1 = 5'd7; cfg_input_first = 1'b1; cfg_loopback = 1'b0;
    cfg_clk_idle_high = 1'b0; cfg_half_div = 8'd1; out_wdata = '0;
    do_reset();

    // R12 reset state
    check("R12 err_flags after reset", {26'd0, err_flags}, 32'd0);
    check("R12 status after reset", {28'd0, status}, 32'd0);
    check("R12 sclk low", {31'd0, sclk}, 32'd0);
    check("R12 mosi low", {31'd0, mosi}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      int n, dv;
      logic [31:0] exp_rx;
      v = VEC[i];
      cfg_bits_m1 = v[79:75]; cfg_input_first = v[74]; cfg_loopback = v[73];
      cfg_clk_idle_high = v[72]; cfg_half_div = v[71:64];
      n  = (int'(v[79:75]) < 3) ? 4 : int'(v[79:75]) + 1;
      dv = (v[71:64] == 8'd0) ? 1 : int'(v[71:64]);
      exp_rx = v[73] ? (v[63:32] >> (32 - n)) : (v[31:0] >> (32 - n));
      cyc(3);
      clear_all();
      sd = v[31:0]; mon = '0; eidx = 0; b_if = v[74]; b_idle = v[72]; mon_en = 1'b1;
      push_word(v[63:32]);
      run = 1'b1;
      wait_bit(1, 1'b1, 1'b0);
      cyc(2);
      run = 1'b0; mon_en = 1'b0;
      cyc(1);
      check($sformatf("R1 edge count vec%0d", i), eidx, 2 * n);
      check($sformatf("R2 R4 mosi bits vec%0d", i), mon, v[63:32] >> (32 - n));
      check($sformatf("R5 idle level vec%0d", i), {31'd0, sclk}, {31'd0, v[72]});
      check($sformatf("R5 half period vec%0d", i), int'((t_e1 - t_e0) / 20), dv);
      check($sformatf("R9 out underrun flag vec%0d", i), {31'd0, err_flags[3]}, 32'd1);
      in_rd = 1'b1;
      cyc(1);
      in_rd = 1'b0;
      if (v[73]) check($sformatf("R3 R6 rx word vec%0d", i), in_rdata, exp_rx);
      else       check($sformatf("R3 R4 rx word vec%0d", i), in_rdata, exp_rx);
    end

    // R8 transmit overflow, R7 status, R11 clearing
    do_reset();
    for (int k = 0; k < 8; k++) push_word(32'h1000_0000 * (k + 1));
    check("R7 out full status", {28'd0, status}, 32'h5);
    check("R8 no flag before overflow", {26'd0, err_flags}, 32'd0);
    push_word(32'hFFFF_FFFF);
    check("R8 out overrun flag", {26'd0, err_flags}, 32'h20);
    cyc(2);
    check("R11 flag sticky", {26'd0, err_flags}, 32'h20);
    err_clr = 6'h20; cyc(1); err_clr = '0;
    check("R11 W1C clears", {26'd0, err_flags}, 32'd0);
    in_rd = 1'b1; cyc(1); in_rd = 1'b0;
    check("R8 in underrun flag", {26'd0, err_flags}, 32'h10);
    err_clr = 6'h20; cyc(1); err_clr = '0;
    check("R11 other bit clear keeps flag", {26'd0, err_flags}, 32'h10);

    // R9 receive overflow
    do_reset();
    cfg_bits_m1 = 5'd3; cfg_half_div = 8'd1; cfg_input_first = 1'b1;
    cfg_loopback = 1'b1; cfg_clk_idle_high = 1'b0;
    for (int k = 0; k < 8; k++) push_word(32'h1000_0000 * (k + 1));
    run = 1'b1;
    wait_bit(0, 1'b0, 1'b0);
    push_word(32'hF000_0000);
    wait_bit(2, 1'b1, 1'b1);
    check("R9 in overrun flag", {31'd0, err_flags[2]}, 32'd1);
    check("R7 in full status", {31'd0, status[3]}, 32'd1);
    run = 1'b0;
    in_rd = 1'b1; cyc(1); in_rd = 1'b0;
    check("R9 oldest word kept", in_rdata, 32'h1);

    // R10 clock disturbances
    do_reset();
    cfg_bits_m1 = 5'd31; cfg_half_div = 8'd8; cfg_input_first = 1'b0;
    cfg_loopback = 1'b1; cfg_clk_idle_high = 1'b1;
    cyc(2);
    push_word(32'h8765_4321);
    run = 1'b1;
    cyc(30);
    check("R10 no clock overrun yet", {31'd0, err_flags[1]}, 32'd0);
    cfg_half_div = 8'd5;
    cyc(2);
    check("R10 clock overrun flag", {31'd0, err_flags[1]}, 32'd1);
    check("R10 no clock underrun yet", {31'd0, err_flags[0]}, 32'd0);
    run = 1'b0;
    cyc(2);
    check("R10 clock underrun flag", {31'd0, err_flags[0]}, 32'd1);
    check("R10 sclk back to idle", {31'd0, sclk}, 32'd1);
    check("R10 abandoned word not queued", {31'd0, status[1]}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule